// File: doc/BRIEF.md
# I2C-over-AUX EDID Responder

This block stands in for the register set of a display auxiliary channel. It has one control register and five data registers. The host uses it to read display identification data over I2C-over-AUX requests. A request header goes into the first data register. The host then writes the control register with the send-busy bit set. The transaction completes in that same clock edge. The control register takes on the done flag and a reply size, and the first data register takes on the synthesized reply.

Address-only requests drive a small session machine. A start to the identification address selects the target. A stop, or a start to address zero, clears the target. Each read request returns one byte from an internal 128-byte identification table, or 0xFF when no target is ready. A read pointer steps through the table. Write requests are acknowledged, and their payload is dropped.

Top module: `aux_edid_responder`

## Requirements
- R1: The offsets 0x14, 0x18, 0x1C, 0x20 and 0x24 select data registers 1 to 5. A write there is stored unchanged and can be read back. Offset 0x10 reads the control register. Every other offset ignores writes and reads as 0. After reset, all registers read 0.
- R2: A write to the control register with bit 31 (send-busy) clear changes neither the control register, data register 1, nor the session.
- R3: When a transaction starts, data register 1 supplies the request. The operation is bits 31:28: op bit 0 (bit 28) means read, and op bit 2 (bit 30) means middle-of-transaction. The target address is bits 23:8. The request length comes from bits 24:20 of the control write.
- R4: After a transaction, the control register reads exactly done (bit 30) plus a reply size in bits 24:20. The size is 2 when op bit 0 is set and 1 otherwise.
- R5: A length-3 request is address-only. With middle-of-transaction clear, or with address 0, it clears the session: the target is deselected, availability is cleared, and the pointer returns to 0. With middle-of-transaction set and address 0x50, it selects the target and marks it available if monitor_present is high. Any other address leaves the session unchanged.
- R6: A write request (op bit 0 clear) that is not address-only is acknowledged with 0x00000000 in data register 1. It does not move the read pointer.
- R7: A read request of length 4 replies with the next table byte in bits 23:16 of data register 1 when the target is selected and available, and the pointer then advances. Otherwise it replies with 0xFF. A read request of any other length, except 3, leaves data register 1 and the pointer unchanged.
- R8: Every reply that writes data register 1 carries the ACK code 0x00 in bits 31:24 and zeros in bits 15:0.
- R9: The table holds 128 bytes. Byte i is ((37*i + 11) mod 256) XOR (i with its two nibbles swapped). Reads at or past index 128 return 0x00, and the pointer stays at 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_offset | input | 8 | Low byte of the write offset |
| wr_data | input | 32 | Write data |
| rd_offset | input | 8 | Low byte of the read offset |
| rd_data | output | 32 | Combinational read data |
| monitor_present | input | 1 | A display that can serve identification data is attached |

## Verification
The bench looks for corner cases in the session logic. A stop must reset the pointer. If it does not, the next session resumes mid-table. A start while no monitor is attached must still give 0xFF. If the design got this wrong, it would leak table bytes. At the end of the table, a wrong design would wrap or return stale data instead of 0x00. The bench also checks that a read with a bad length and a write request both leave the pointer unchanged. A design that advanced the pointer on these would skip a byte on the next read. It also checks that a control write without busy is inert. A design that got this wrong would overwrite the done status.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;
  localparam logic [7:0] CTRL_OFS  = 8'h10;
  localparam logic [7:0] DATA_BASE = 8'h14;
  localparam int BUSY_BIT  = 31;
  localparam int DONE_BIT  = 30;
  localparam int SIZE_LSB  = 20;
  localparam int SIZE_W    = 5;
  localparam logic [7:0] ACK_CODE  = 8'h00;
  localparam logic [7:0] NO_TARGET = 8'hFF;

  typedef struct packed {
    logic [3:0]        op;
    logic [15:0]       addr;
    logic [SIZE_W-1:0] len;
  } aux_req_t;

  function automatic aux_req_t req_decode(input logic [31:0] hdr, input logic [31:0] ctl);
    aux_req_t r;
    r.op   = hdr[31:28];
    r.addr = hdr[23:8];
    r.len  = ctl[SIZE_LSB +: SIZE_W];
    return r;
  endfunction

  function automatic logic [SIZE_W-1:0] reply_size(input logic is_rd);
    return is_rd ? SIZE_W'(2) : SIZE_W'(1);
  endfunction

  function automatic logic [7:0] edid_rom(input logic [7:0] idx);
    return (idx * 8'd37 + 8'd11) ^ {idx[3:0], idx[7:4]};
  endfunction
endpackage

// File: rtl/aux_reg_decode.sv
module aux_reg_decode import aux_edid_pkg::*; #(
  parameter int NUM_DATA = 5,
  localparam int IDX_W = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
  input  logic [7:0]       offset,
  output logic             is_ctrl,
  output logic             is_data,
  output logic [IDX_W-1:0] data_idx
);
  logic [7:0] rel;
  assign rel      = offset - DATA_BASE;
  assign is_ctrl  = (offset == CTRL_OFS);
  assign is_data  = (offset >= DATA_BASE) && (rel < 8'(4 * NUM_DATA)) && (offset[1:0] == 2'b00);
  assign data_idx = rel[IDX_W+1:2];
endmodule

// File: rtl/aux_req_parse.sv
module aux_req_parse import aux_edid_pkg::*; (
  input  logic [31:0] hdr,
  input  logic [31:0] ctl,
  output logic [15:0] addr,
  output logic        rd_op,
  output logic        mot,
  output logic        addr_only,
  output logic        read_len4
);
  aux_req_t req;
  assign req       = req_decode(hdr, ctl);
  assign addr      = req.addr;
  assign rd_op     = req.op[0];
  assign mot       = req.op[2];
  assign addr_only = (req.len == SIZE_W'(3));
  assign read_len4 = req.op[0] && (req.len == SIZE_W'(4));
endmodule

// File: rtl/aux_edid_session.sv
module aux_edid_session import aux_edid_pkg::*; #(
  parameter int          EDID_BYTES = 128,
  parameter logic [15:0] EDID_ADDR  = 16'h0050,
  localparam int PTR_W = $clog2(EDID_BYTES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        txn_fire,
  input  logic        addr_only,
  input  logic        mot,
  input  logic [15:0] addr,
  input  logic        read_len4,
  input  logic        monitor_present,
  output logic        edid_ready,
  output logic [7:0]  reply_byte
);
  logic             sel_q, avail_q;
  logic [PTR_W-1:0] ptr_q;
  logic             sess_clear, sess_select, byte_fetch, ptr_in_range;
  logic [7:0]       table_byte;

  assign sess_clear   = txn_fire && addr_only && (!mot || addr == 16'h0000);
  assign sess_select  = txn_fire && addr_only && mot && (addr == EDID_ADDR);
  assign edid_ready   = sel_q && avail_q;
  assign byte_fetch   = txn_fire && read_len4 && edid_ready;
  assign ptr_in_range = (ptr_q < PTR_W'(EDID_BYTES));
  assign table_byte   = ptr_in_range ? edid_rom(8'(ptr_q)) : 8'h00;
  assign reply_byte   = edid_ready ? table_byte : NO_TARGET;

  always_ff @(posedge clk) begin
    if (!rst_n || sess_clear) begin
      sel_q   <= 1'b0;
      avail_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      if (sess_select) begin
        sel_q <= 1'b1;
        if (monitor_present) avail_q <= 1'b1;
      end
      if (byte_fetch && ptr_in_range) ptr_q <= ptr_q + 1'b1;
    end
  end

  AST_CLEAR_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
    sess_clear |=> (ptr_q == '0) && !edid_ready); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !sess_clear |=> (ptr_q == $past(ptr_q)) || (ptr_q == $past(ptr_q) + 1'b1)); // R7
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_W'(EDID_BYTES)); // R9
  AST_NO_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_fire && !read_len4 && !addr_only) |=> $stable(ptr_q)); // R6
endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder import aux_edid_pkg::*; #(
  parameter int          EDID_BYTES = 128,
  parameter logic [15:0] EDID_ADDR  = 16'h0050,
  parameter int          NUM_DATA   = 5,
  localparam int IDX_W = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_offset,
  input  logic [31:0] wr_data,
  input  logic [7:0]  rd_offset,
  output logic [31:0] rd_data,
  input  logic        monitor_present
);
  logic [31:0]      ctrl_q;
  logic [31:0]      data_q [NUM_DATA];
  logic             wr_is_ctrl, wr_is_data, rd_is_ctrl, rd_is_data;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [15:0]      req_addr;
  logic             rd_op, mot, addr_only, read_len4;
  logic             txn_fire, reply_we, edid_ready;
  logic [7:0]       reply_byte;
  logic [31:0]      reply_word;

  aux_reg_decode #(.NUM_DATA(NUM_DATA)) u_wdec (
    .offset(wr_offset), .is_ctrl(wr_is_ctrl), .is_data(wr_is_data), .data_idx(wr_idx));
  aux_reg_decode #(.NUM_DATA(NUM_DATA)) u_rdec (
    .offset(rd_offset), .is_ctrl(rd_is_ctrl), .is_data(rd_is_data), .data_idx(rd_idx));

  aux_req_parse u_parse (
    .hdr(data_q[0]), .ctl(wr_data), .addr(req_addr), .rd_op(rd_op), .mot(mot),
    .addr_only(addr_only), .read_len4(read_len4));

  assign txn_fire   = wr_en && wr_is_ctrl && wr_data[BUSY_BIT];
  assign reply_we   = txn_fire && (addr_only || !rd_op || read_len4);
  assign reply_word = {ACK_CODE, (read_len4 && !addr_only) ? reply_byte : 8'h00, 16'h0000};

  aux_edid_session #(.EDID_BYTES(EDID_BYTES), .EDID_ADDR(EDID_ADDR)) u_sess (
    .clk(clk), .rst_n(rst_n), .txn_fire(txn_fire), .addr_only(addr_only), .mot(mot),
    .addr(req_addr), .read_len4(read_len4 && !addr_only), .monitor_present(monitor_present),
    .edid_ready(edid_ready), .reply_byte(reply_byte));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int i = 0; i < NUM_DATA; i++) data_q[i] <= '0;
    end else begin
      if (txn_fire) begin
        ctrl_q <= '0;
        ctrl_q[DONE_BIT] <= 1'b1;
        ctrl_q[SIZE_LSB +: SIZE_W] <= reply_size(rd_op);
      end
      for (int i = 0; i < NUM_DATA; i++) begin
        if (wr_en && wr_is_data && wr_idx == IDX_W'(i)) data_q[i] <= wr_data;
        else if (i == 0 && reply_we) data_q[i] <= reply_word;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_is_ctrl) rd_data = ctrl_q;
    else if (rd_is_data) rd_data = data_q[rd_idx];
  end

  AST_IDLE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_is_ctrl && !wr_data[BUSY_BIT]) |=> $stable(ctrl_q) && $stable(data_q[0])); // R2
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    txn_fire |=> ctrl_q[DONE_BIT] && !ctrl_q[BUSY_BIT]); // R4
  AST_REPLY_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_fire |=> ctrl_q[SIZE_LSB +: SIZE_W] == ($past(rd_op) ? SIZE_W'(2) : SIZE_W'(1))); // R4
  AST_ACK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    reply_we |=> (data_q[0][31:24] == ACK_CODE) && (data_q[0][15:0] == 16'h0000)); // R8
  AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_fire && !addr_only && !rd_op) |=> data_q[0] == 32'h0); // R6
  AST_FF_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_fire && read_len4 && !addr_only && !edid_ready) |=> data_q[0][23:16] == NO_TARGET); // R7
endmodule

// File: tb/aux_edid_responder_test.sv
module aux_edid_responder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_offset = 8'h00;
  logic [31:0] wr_data = 32'h0;
  logic [7:0]  rd_offset = 8'h00;
  logic [31:0] rd_data;
  logic        monitor_present = 1'b0;

  always #5 clk = ~clk;

  aux_edid_responder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_offset(wr_offset), .wr_data(wr_data),
    .rd_offset(rd_offset), .rd_data(rd_data), .monitor_present(monitor_present));

  typedef struct {
    logic [7:0]  off;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int compared = 0, mismatched = 0;
  bit mon_busy = 0, finished = 0;

  // reference model
  logic [31:0] m_ctrl = 0;
  logic [31:0] m_d [5] = '{default: 0};
  bit m_sel = 0, m_avail = 0;
  int m_ptr = 0;

  function automatic logic [7:0] ref_byte(input int i);
    int a = (i * 37 + 11) % 256;
    int b = ((i % 16) * 16) + (i / 16);
    return 8'(a ^ b);
  endfunction

  task automatic expect_reg(input logic [7:0] off, input logic [31:0] exp, input string tag);
    item_t it;
    it.off = off; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic sync();
    wait (q.size() == 0 && !mon_busy);
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_offset = off; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (off >= 8'h14 && off <= 8'h24 && off[1:0] == 2'b00) m_d[(off - 8'h14) >> 2] = d;
  endtask

  task automatic check_all(input string tag);
    expect_reg(8'h10, m_ctrl, tag);
    for (int i = 0; i < 5; i++) expect_reg(8'(8'h14 + 4 * i), m_d[i], tag);
    sync();
  endtask

  task automatic aux_txn(input logic [3:0] op, input logic [15:0] addr, input int len, input string tag);
    logic [7:0] b;
    wr(8'h14, {op, 4'h0, addr, 8'h00});
    wr(8'h10, 32'h8000_0000 | (32'(len) << 20));
    m_ctrl = 32'h4000_0000 | ((op[0] ? 32'd2 : 32'd1) << 20);
    if (len == 3) begin
      if (!op[2] || addr == 16'h0) begin m_sel = 0; m_avail = 0; m_ptr = 0; end
      else if (addr == 16'h0050) begin m_sel = 1; if (monitor_present) m_avail = 1; end
      m_d[0] = 32'h0;
    end else if (!op[0]) begin
      m_d[0] = 32'h0;
    end else if (len == 4) begin
      if (m_sel && m_avail) begin
        b = (m_ptr < 128) ? ref_byte(m_ptr) : 8'h00;
        if (m_ptr < 128) m_ptr++;
      end else b = 8'hFF;
      m_d[0] = {8'h00, b, 16'h0};
    end
    expect_reg(8'h10, m_ctrl, tag);
    expect_reg(8'h14, m_d[0], tag);
    sync();
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        mon_busy = 1;
        it = q.pop_front();
        rd_offset = it.off;
        #1;
        compared++;
        if (rd_data !== it.exp) begin
          mismatched++;
          $display("FAIL %s: offset %h got %h expected %h", it.tag, it.off, rd_data, it.exp);
        end
        mon_busy = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    // R1: data register storage and unknown offsets
    wr(8'h18, 32'hA1B2_C3D4); wr(8'h1C, 32'h1111_2222);
    wr(8'h20, 32'hDEAD_BEEF); wr(8'h24, 32'h0BAD_F00D); wr(8'h14, 32'h1234_5678);
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h16, 32'h5555_5555);
    check_all("R1 data store");
    expect_reg(8'h28, 32'h0, "R1 unknown offset"); sync();
    // R2: control write without busy
    wr(8'h10, 32'h4050_0000);
    check_all("R2 no busy");
    // R7: read before any selection gives 0xFF, R4 size 2
    monitor_present = 1'b1;
    aux_txn(4'h5, 16'h0, 4, "R7 unselected read");
    // R5: start to identification address; R8 ack
    aux_txn(4'h4, 16'h0050, 3, "R5 start select");
    for (int i = 0; i < 3; i++) aux_txn(4'h5, 16'h0, 4, "R7 read byte");
    // R6: write request is acked, pointer unmoved
    aux_txn(4'h4, 16'h0050, 5, "R6 write ignored");
    aux_txn(4'h5, 16'h0, 4, "R6 pointer held");
    // R7: read with wrong length leaves data1 and pointer
    aux_txn(4'h5, 16'h0, 6, "R7 bad length");
    aux_txn(4'h5, 16'h0, 4, "R7 pointer after bad length");
    // R5: start to other address changes nothing
    aux_txn(4'h4, 16'h0037, 3, "R5 other address");
    aux_txn(4'h5, 16'h0, 4, "R5 other address keeps session");
    // R5: stop (read op, size 2) clears session
    aux_txn(4'h1, 16'h0050, 3, "R5 stop");
    aux_txn(4'h5, 16'h0, 4, "R5 after stop");
    // R5: start without monitor selects but not available
    monitor_present = 1'b0;
    aux_txn(4'h4, 16'h0050, 3, "R5 start no monitor");
    aux_txn(4'h5, 16'h0, 4, "R5 no monitor gives FF");
    // R5: address 0 with MOT clears
    monitor_present = 1'b1;
    aux_txn(4'h4, 16'h0050, 3, "R5 restart");
    aux_txn(4'h5, 16'h0, 4, "R3 read from zero");
    aux_txn(4'h4, 16'h0000, 3, "R5 address zero clear");
    aux_txn(4'h5, 16'h0, 4, "R5 after address zero");
    // R9: walk full table and past its end
    aux_txn(4'h4, 16'h0050, 3, "R9 start");
    for (int i = 0; i < 131; i++) aux_txn(4'h5, 16'h0, 4, "R9 table walk");
    check_all("R8 final state");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule